// File: doc/BRIEF.md
# Move-Only Processor Core with Trigger-Port Arithmetic

The core runs a program made of a single kind of instruction: a move that copies one data word from a numbered source port to a numbered destination port over one shared transport bus. Arithmetic has no opcodes. An adder unit and a multiplier unit each have an operand port, a trigger port and a result port. Writing a word into a trigger port starts that unit's operation, and the result can be read by any later move. A small register file, an input stream and an output stream are reached through the same port numbering. Because a unit's result port is an ordinary source, a move can carry a result straight into another unit's operand or trigger port without passing through the register file.

The program sits in an internal read-only store set by a parameter. The core executes one move per clock. A move that reads the input stream waits for a word to arrive. A move that writes the output stream waits until the consumer accepts the word. The program counter stops at a halt move, and the core then stays idle until the next reset.

Top module: `tta_core`

## Requirements
- R1: Each move is 10 bits wide, with the source port ID in bits 9:5 and the destination port ID in bits 4:0. Move k of the program sits in bits [10k+9:10k] of the PROG parameter. The core completes one move per clock when it is not stalled, so the built-in 21-move program reaches halt 20 cycles after its first move starts. The move with source 31 and destination 31 halts the core: halted goes high, and after that no input is consumed and no output is offered.
- R2: Port IDs 0 to 7 are the eight register-file words. They can be read and written, and a value written there reads back unchanged in later moves.
- R3: The adder uses ID 8 as its operand port, ID 9 as its trigger port and ID 10 as its result port. The multiplier uses IDs 12, 13 and 14 in the same roles. A write to the operand port only stores the word. A write to the trigger port makes the result the stored operand combined with the written word: the sum modulo 2^DATA_W for the adder, and the low DATA_W bits of the product for the multiplier. A move in the very next cycle reads the new result.
- R4: A result port keeps its value until the next write to the same unit's trigger port.
- R5: A move whose source is a result port and whose destination is another unit's operand or trigger port passes the value directly.
- R6: Reading ID 16 takes one word from the input stream, with the handshake in_valid and in_ready both high in one cycle. While in_valid is low the core stalls with in_ready held high and makes no progress.
- R7: Writing ID 17 offers the bus word on out_data with out_valid high. The word transfers when out_ready is high. Until then out_valid and out_data stay unchanged.
- R8: A move to an output-only port (10 or 14) or to an unmapped ID has no effect on any stored value.
- R9: A move from an unmapped ID or from an input-only port (for example ID 8) delivers zero.
- R10: While rst_n is low, in_ready, out_valid and halted are low. Registers and unit results reset to zero. The core starts at move 0 two clocks after rst_n rises.
- R11: The built-in program reads a, b and c, then emits six words in this order: a+b*b, (c+b*b)*a, c+b*b, b, 0, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_data | input | DATA_W | Input stream word |
| in_valid | input | 1 | Input stream word present |
| in_ready | output | 1 | Core takes the input word this cycle |
| out_data | output | DATA_W | Output stream word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer accepts the output word |
| halted | output | 1 | Program counter sits on a halt move |

## Verification
The built-in program runs once per reset with operands drawn from a fixed-seed random source, plus directed operands of zero, all ones and values that force the sum and the product to wrap. Input valid and output ready are varied per run. Full-throughput runs pin down the exact move count. Random gaps in valid and ready show that stalls neither lose nor duplicate words, and a long input starvation at the start shows that the core holds with nothing consumed. The six outputs tell the data paths apart: the register-file path, the direct unit-to-unit path, a result that must persist across ignored writes to output-only and unmapped ports, a register that unmapped writes must not touch, and the zero reads from unmapped and input-only sources.

// File: rtl/tta_pkg.sv
package tta_pkg;

  localparam int PID_W  = 5;
  localparam int MOVE_W = 2 * PID_W;

  localparam logic [PID_W-1:0] P_ADD_OP  = 5'd8;
  localparam logic [PID_W-1:0] P_ADD_TRG = 5'd9;
  localparam logic [PID_W-1:0] P_ADD_RES = 5'd10;
  localparam logic [PID_W-1:0] P_MUL_OP  = 5'd12;
  localparam logic [PID_W-1:0] P_MUL_TRG = 5'd13;
  localparam logic [PID_W-1:0] P_MUL_RES = 5'd14;
  localparam logic [PID_W-1:0] P_IO_IN   = 5'd16;
  localparam logic [PID_W-1:0] P_IO_OUT  = 5'd17;
  localparam logic [PID_W-1:0] P_NOWHERE = 5'd20;
  localparam logic [PID_W-1:0] P_VOID    = 5'd25;
  localparam logic [PID_W-1:0] P_HALT    = 5'd31;

  typedef struct packed {
    logic [PID_W-1:0] src;
    logic [PID_W-1:0] dst;
  } move_t;

  typedef enum logic {FU_ADD, FU_MUL} fu_kind_e;

  function automatic logic [MOVE_W-1:0] mv(logic [PID_W-1:0] s, logic [PID_W-1:0] d);
    return {s, d};
  endfunction

  localparam int DEMO_LEN = 21;

  // entry 0 is the least significant slice
  localparam logic [DEMO_LEN*MOVE_W-1:0] DEMO_PROG = {
    mv(P_HALT,    P_HALT),     // 20
    mv(P_ADD_OP,  P_IO_OUT),   // 19 input-only source -> 0
    mv(5'd3,      P_IO_OUT),   // 18 r3 -> out (0)
    mv(P_NOWHERE, 5'd3),       // 17 unmapped source -> r3
    mv(5'd1,      P_IO_OUT),   // 16 r1 -> out (b)
    mv(P_ADD_RES, P_IO_OUT),   // 15 add result -> out (c+b*b)
    mv(5'd0,      P_VOID),     // 14 ignored
    mv(5'd0,      P_ADD_RES),  // 13 ignored
    mv(P_MUL_RES, P_IO_OUT),   // 12 (c+b*b)*a -> out
    mv(5'd0,      P_MUL_TRG),  // 11
    mv(P_ADD_RES, P_MUL_OP),   // 10 direct
    mv(P_MUL_RES, P_ADD_TRG),  // 9 direct
    mv(P_IO_IN,   P_ADD_OP),   // 8 c
    mv(P_ADD_RES, P_IO_OUT),   // 7 a+b*b -> out
    mv(5'd2,      P_ADD_TRG),  // 6
    mv(5'd0,      P_ADD_OP),   // 5
    mv(P_MUL_RES, 5'd2),       // 4
    mv(5'd1,      P_MUL_TRG),  // 3
    mv(5'd1,      P_MUL_OP),   // 2
    mv(P_IO_IN,   5'd1),       // 1 b
    mv(P_IO_IN,   5'd0)        // 0 a
  };

endpackage

// File: rtl/tta_rst_sync.sv
module tta_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/tta_fetch.sv
module tta_fetch
  import tta_pkg::*;
#(
  parameter int DEPTH = DEMO_LEN,
  parameter logic [DEPTH*MOVE_W-1:0] PROG = DEMO_PROG
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  output move_t cur,
  output logic  halted
);
  localparam int PC_W  = $clog2(DEPTH + 1);
  localparam int ROM_N = 1 << PC_W;
  localparam logic [MOVE_W-1:0] HALT_MV = {P_HALT, P_HALT};

  logic [MOVE_W-1:0] rom [ROM_N];
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   pc_d;

  for (genvar i = 0; i < ROM_N; i++) begin : g_rom
    if (i < DEPTH) begin : g_used
      assign rom[i] = PROG[i*MOVE_W +: MOVE_W];
    end else begin : g_pad
      assign rom[i] = HALT_MV;
    end
  end

  assign cur    = move_t'(rom[pc_q]);
  assign halted = (rom[pc_q] == HALT_MV);

  always_comb begin
    pc_d = pc_q;
    if (advance && !halted) pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R1
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted) else $error("halt left");

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (pc_q != $past(pc_q))) else $error("pc did not step");
endmodule

// File: rtl/tta_fu.sv
module tta_fu
  import tta_pkg::*;
#(
  parameter int       DATA_W = 16,
  parameter fu_kind_e KIND   = FU_ADD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_we,
  input  logic              trg_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] op_q, op_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [DATA_W-1:0] calc;

  if (KIND == FU_MUL) begin : g_mul
    assign calc = op_q * wdata;
  end else begin : g_add
    assign calc = op_q + wdata;
  end

  always_comb begin
    op_d  = op_q;
    res_d = res_q;
    if (op_we)  op_d  = wdata;
    if (trg_we) res_d = calc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      res_q <= '0;
    end else begin
      op_q  <= op_d;
      res_q <= res_d;
    end
  end

  assign res = res_q;

  // R4
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trg_we |=> $stable(res)) else $error("result moved without trigger");
endmodule

// File: rtl/tta_regfile.sv
module tta_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit;
    assign hit = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[i] <= '0;
      else if (hit) word_q[i] <= wdata;
    end
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/tta_core.sv
module tta_core
  import tta_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RF_DEPTH = 8,
  parameter int PROG_LEN = DEMO_LEN,
  parameter logic [PROG_LEN*MOVE_W-1:0] PROG = DEMO_PROG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              halted
);
  localparam int RF_AW = $clog2(RF_DEPTH);
  localparam logic [PID_W-1:0] RF_TOP = PID_W'(RF_DEPTH);

  logic              live_n;
  move_t             cur;
  logic              at_halt;
  logic              active, need_in, need_out, in_ok, out_ok, advance;
  logic [DATA_W-1:0] bus;
  logic [DATA_W-1:0] rf_rdata, add_res, mul_res;
  logic              rf_we, add_op_we, add_trg_we, mul_op_we, mul_trg_we;

  tta_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(live_n));

  tta_fetch #(.DEPTH(PROG_LEN), .PROG(PROG)) u_fetch (
    .clk(clk), .rst_n(live_n), .advance(advance), .cur(cur), .halted(at_halt)
  );

  // handshake and stall control
  always_comb begin
    active   = live_n && !at_halt;
    need_in  = active && (cur.src == P_IO_IN);
    need_out = active && (cur.dst == P_IO_OUT);
    in_ok    = !need_in  || in_valid;
    out_ok   = !need_out || out_ready;
    advance  = active && in_ok && out_ok;
  end

  assign in_ready  = need_in && out_ok;
  assign out_valid = need_out && in_ok;
  assign halted    = live_n && at_halt;

  // source side of the transport bus
  always_comb begin
    if (cur.src < RF_TOP)          bus = rf_rdata;
    else if (cur.src == P_ADD_RES) bus = add_res;
    else if (cur.src == P_MUL_RES) bus = mul_res;
    else if (cur.src == P_IO_IN)   bus = in_data;
    else                           bus = '0;
  end

  assign out_data = bus;

  // destination side
  always_comb begin
    rf_we      = advance && (cur.dst < RF_TOP);
    add_op_we  = advance && (cur.dst == P_ADD_OP);
    add_trg_we = advance && (cur.dst == P_ADD_TRG);
    mul_op_we  = advance && (cur.dst == P_MUL_OP);
    mul_trg_we = advance && (cur.dst == P_MUL_TRG);
  end

  tta_regfile #(.DATA_W(DATA_W), .DEPTH(RF_DEPTH)) u_rf (
    .clk(clk), .rst_n(live_n), .we(rf_we),
    .waddr(cur.dst[RF_AW-1:0]), .wdata(bus),
    .raddr(cur.src[RF_AW-1:0]), .rdata(rf_rdata)
  );

  tta_fu #(.DATA_W(DATA_W), .KIND(FU_ADD)) u_add (
    .clk(clk), .rst_n(live_n), .op_we(add_op_we), .trg_we(add_trg_we),
    .wdata(bus), .res(add_res)
  );

  tta_fu #(.DATA_W(DATA_W), .KIND(FU_MUL)) u_mul (
    .clk(clk), .rst_n(live_n), .op_we(mul_op_we), .trg_we(mul_trg_we),
    .wdata(bus), .res(mul_res)
  );

  // R6
  in_stall_chk: assert property (@(posedge clk) disable iff (!live_n)
    (in_ready && !in_valid) |=> in_ready) else $error("input stall dropped");

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!live_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("output word not held");
endmodule

// File: tb/tta_core_bench.sv
module tta_core_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] in_data;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] out_data;
  logic         out_valid;
  logic         out_ready;
  logic         halted;

  tta_core u_tta_core (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .halted(halted)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [W-1:0] inq [3];
  logic [W-1:0] outs [8];
  int in_idx, out_cnt, vpct, rpct, hold_off;
  bit pend;
  logic [W-1:0] held;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_out(int k, logic [W-1:0] a,
                                              logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] bb, s;
    bb = b * b;
    s  = c + bb;
    case (k)
      0: return a + bb;
      1: return s * a;
      2: return s;
      3: return b;
      default: return '0;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    if (hold_off > 0) begin
      in_valid = 1'b0;
      hold_off--;
    end else begin
      in_valid = (in_idx < 3) && (($urandom % 100) < vpct);
    end
    in_data   = (in_idx < 3) ? inq[in_idx] : '0;
    out_ready = ($urandom % 100) < rpct;
    #5;
    if (pend) begin
      // R7 offered word stays until accepted
      chk(out_valid && (out_data == held), "R7", "held output", out_data, held);
    end
    if (in_valid && in_ready) in_idx++;
    if (out_valid && out_ready) begin
      if (out_cnt < 8) outs[out_cnt] = out_data;
      out_cnt++;
    end
    pend = out_valid && !out_ready;
    held = out_data;
    cycles++;
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                     input int vp, input int rp, input bit exact, input int starve);
    int moves;
    bit started, timed_out;
    inq[0] = a; inq[1] = b; inq[2] = c;
    in_idx = 0; out_cnt = 0; pend = 1'b0; hold_off = 0;
    vpct = vp; rpct = rp;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    // R10 outputs idle while reset is low
    chk(!in_ready && !out_valid && !halted, "R10", "reset state",
        {13'd0, in_ready, out_valid, halted}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    hold_off = starve;
    if (starve > 0) begin
      for (int i = 0; i < starve; i++) step();
      // R6 starved input: nothing consumed, nothing emitted, still waiting
      chk(in_idx == 0 && out_cnt == 0 && in_ready, "R6", "starved stall",
          W'(in_idx + out_cnt), '0);
    end
    moves = 0; started = 0; timed_out = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      if (in_ready) started = 1;
      if (halted) break;
      if (started) moves++;
      if (i == 599) timed_out = 1;
    end
    chk(!timed_out, "R1", "watchdog", W'(timed_out), '0);
    if (exact) chk(moves == 20, "R1", "move count at full rate", W'(moves), W'(20));
    for (int i = 0; i < 5; i++) step();
    // R1 halted core stays quiet
    chk(halted && !in_ready && !out_valid, "R1", "halt idle",
        {13'd0, halted, in_ready, out_valid}, 16'h4);
    chk(in_idx == 3, "R6", "words consumed", W'(in_idx), W'(3));
    chk(out_cnt == 6, "R7", "words emitted", W'(out_cnt), W'(6));
    if (out_cnt >= 6) begin
      chk(outs[0] == expect_out(0, a, b, c), "R11", "a+b*b via RF R3", outs[0], expect_out(0, a, b, c));
      chk(outs[1] == expect_out(1, a, b, c), "R5", "direct unit chain", outs[1], expect_out(1, a, b, c));
      chk(outs[2] == expect_out(2, a, b, c), "R4", "result kept past R8 writes", outs[2], expect_out(2, a, b, c));
      chk(outs[3] == expect_out(3, a, b, c), "R2", "register untouched by unmapped write R8", outs[3], expect_out(3, a, b, c));
      chk(outs[4] == '0, "R9", "unmapped source", outs[4], '0);
      chk(outs[5] == '0, "R9", "input-only source", outs[5], '0);
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    in_idx = 0; out_cnt = 0; pend = 1'b0; hold_off = 0; vpct = 100; rpct = 100;
    // directed corners
    run(16'd3, 16'd5, 16'd7, 100, 100, 1'b1, 0);
    run(16'd0, 16'd0, 16'd0, 100, 100, 1'b1, 0);
    run(16'hFFFF, 16'hFFFF, 16'hFFFF, 100, 100, 1'b1, 0);   // R3 wrap
    run(16'hFFFF, 16'd1, 16'h0001, 70, 40, 1'b0, 0);
    run(16'h1234, 16'h0100, 16'h00FF, 100, 100, 1'b0, 12);  // R6 starvation
    // random runs with mixed handshake rates
    for (int r = 0; r < 30; r++) begin
      logic [W-1:0] ra, rb, rc;
      int vp, rp;
      ra = W'($urandom); rb = W'($urandom); rc = W'($urandom);
      if (rb == ra) rb = ra ^ 16'h0101;
      vp = 30 + ($urandom % 71);
      rp = 30 + ($urandom % 71);
      run(ra, rb, rc, vp, rp, 1'b0, 0);
      if (cycles > 150000) break;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule